// File: doc/BRIEF.md
# Desaturation Protection and Soft-Shutdown Channel

This block is the protection logic for one gate-drive channel of a half bridge. It accepts a logic-level on/off command and a digitized desaturation comparator bit. It produces four mutually exclusive drive enables: a strong first-stage pull-up, a weaker holding pull-up, the normal hard pull-down and a weak soft-shutdown pull-down. Turn-on starts with a short strong stage and then hands over to the holding stage. The desaturation bit is masked for a blanking window that begins at every turn-on.

Once blanking has ended, a desaturation indication becomes a fault only if it persists for a qualification window. A qualified fault releases both pull-ups and the hard pull-down. The gate is then discharged through the soft pull-down for a fixed duration, while an active-low sync line is held low. After that the hard pull-down takes over. A latched fault flag is raised for the fault manager. The channel stays off until the fault manager pulses a clear. Every duration is a parameter counted in system clock cycles.

Top module: `desatGuard`

## Requirements
- R1: After reset only the hard pull-down is enabled, the sync output is high and the fault flag is low.
- R2: After a turn-on command is sampled, the strong pull-up is enabled for exactly FIRST_CYC cycles. The weak pull-up is then enabled for as long as the channel stays on.
- R3: The desaturation input is ignored at every clock edge of the first BLANK_CYC on-cycles after turn-on. A desat pulse confined to that window, or one that only extends into it, never counts toward a fault.
- R4: After blanking, the desaturation input must be sampled high on QUAL_CYC consecutive edges to qualify. A shorter run has no effect. With desat high from on-cycle d, the channel shows max(d, BLANK_CYC) + QUAL_CYC on-cycles before the soft shutdown begins.
- R5: During the soft shutdown, only the soft pull-down is enabled, for exactly SOFT_CYC cycles, and the sync output is low in exactly those cycles.
- R6: The fault flag rises when the soft shutdown begins. It stays high through the soft shutdown and the hard-off state until a clear is accepted.
- R7: After the soft shutdown, the hard pull-down stays enabled and a turn-on command is ignored. A fault-clear pulse returns the channel to the off state with the fault flag low, and a later turn-on works normally.
- R8: Neither a turn-off command nor a fault-clear pulse shortens the soft shutdown.
- R9: A turn-off command during blanking or during normal on-time returns the channel to the off state in the next cycle without a fault.
- R10: While the channel is off, the desaturation input has no effect.
- R11: Exactly one of the four drive enables is active in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| cmdOn | input | 1 | Switch command, 1 = on |
| desatIn | input | 1 | Digitized desaturation comparator, 1 = desaturated |
| faultClear | input | 1 | Fault release pulse from the fault manager |
| pullUpStrong | output | 1 | First-stage strong pull-up enable |
| pullUpWeak | output | 1 | Second-stage holding pull-up enable |
| pullDown | output | 1 | Hard pull-down enable |
| softPullDown | output | 1 | Weak soft-shutdown pull-down enable |
| syncN | output | 1 | Active-low soft-shutdown-in-progress indication |
| faultLatched | output | 1 | Latched desaturation fault flag |

## Verification
The hardest situation to reach from the ports is the exact edge of the qualification window just after blanking ends. A desat run one edge short must leave the switch on, and a run one edge longer must start the shutdown. The stimulus aligns these cases by counting visible on-cycles from turn-on and placing desat pulses relative to that count. It sweeps the start and the length across the blanking boundary, and it computes the expected number of on-cycles before shutdown arithmetically. Interruption of the soft phase is forced by pulsing turn-off and clear in its middle.

// File: rtl/dsatPkg.sv
package dsatPkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_STRONG,
    ST_WEAK,
    ST_SOFT,
    ST_HARD
  } drvState_e;

  // control -> datapath
  typedef struct packed {
    logic clrTmr;
    logic incTmr;
    logic clrQual;
    logic incQual;
    logic setFault;
    logic clrFault;
  } dpStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic firstDone;
    logic blankDone;
    logic desatLive;
    logic qualHit;
    logic softDone;
  } dpFlag_t;

endpackage

// File: rtl/dsatDatapath.sv
module dsatDatapath
  import dsatPkg::*;
#(
  parameter int FIRST_CYC = 50,
  parameter int BLANK_CYC = 750,
  parameter int QUAL_CYC  = 250,
  parameter int SOFT_CYC  = 2312
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      desatIn,
  input  dpStrobe_t strobe,
  output dpFlag_t   flags,
  output logic      faultQ
);

  localparam int TMR_MAX0 = (BLANK_CYC > SOFT_CYC) ? BLANK_CYC : SOFT_CYC;
  localparam int TMR_MAX  = (TMR_MAX0 > FIRST_CYC) ? TMR_MAX0 : FIRST_CYC;
  localparam int TMR_W    = $clog2(TMR_MAX + 1);
  localparam int QUAL_W   = $clog2(QUAL_CYC + 1);

  localparam logic [TMR_W-1:0]  TMR_TOP    = TMR_W'(TMR_MAX);
  localparam logic [TMR_W-1:0]  FIRST_LAST = TMR_W'(FIRST_CYC - 1);
  localparam logic [TMR_W-1:0]  BLANK_END  = TMR_W'(BLANK_CYC);
  localparam logic [TMR_W-1:0]  SOFT_LAST  = TMR_W'(SOFT_CYC - 1);
  localparam logic [QUAL_W-1:0] QUAL_LAST  = QUAL_W'(QUAL_CYC - 1);
  localparam logic [QUAL_W-1:0] QUAL_TOP   = QUAL_W'(QUAL_CYC);

  logic [TMR_W-1:0]  tmr;
  logic [QUAL_W-1:0] qual;

  // phase timer: counts on-time or soft-shutdown time, saturating
  always_ff @(posedge clk) begin
    if (!rstN)                             tmr <= '0;
    else if (strobe.clrTmr)                tmr <= '0;
    else if (strobe.incTmr && tmr != TMR_TOP) tmr <= tmr + 1'b1;
  end

  // consecutive-desat counter
  always_ff @(posedge clk) begin
    if (!rstN)                               qual <= '0;
    else if (strobe.clrQual)                 qual <= '0;
    else if (strobe.incQual && qual != QUAL_TOP) qual <= qual + 1'b1;
  end

  // latched fault flag
  always_ff @(posedge clk) begin
    if (!rstN)                faultQ <= 1'b0;
    else if (strobe.setFault) faultQ <= 1'b1;
    else if (strobe.clrFault) faultQ <= 1'b0;
  end

  always_comb begin
    flags.firstDone = (tmr == FIRST_LAST);
    flags.blankDone = (tmr >= BLANK_END);
    flags.desatLive = desatIn && flags.blankDone;
    flags.qualHit   = flags.desatLive && (qual == QUAL_LAST);
    flags.softDone  = (tmr == SOFT_LAST);
  end

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (faultQ && !strobe.clrFault) |=> faultQ);  // R6

  AST_QUAL_RESETS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrQual |=> (qual == '0));  // R4

endmodule

// File: rtl/dsatCtrl.sv
module dsatCtrl
  import dsatPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdOn,
  input  logic      faultClear,
  input  dpFlag_t   flags,
  output dpStrobe_t strobe,
  output logic      pullUpStrong,
  output logic      pullUpWeak,
  output logic      pullDown,
  output logic      softPullDown,
  output logic      syncN
);

  drvState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_OFF: begin
        strobe.clrTmr  = 1'b1;
        strobe.clrQual = 1'b1;
        if (cmdOn) stateNext = ST_STRONG;
      end
      ST_STRONG, ST_WEAK: begin
        if (!cmdOn) begin
          stateNext      = ST_OFF;
          strobe.clrQual = 1'b1;
        end else if (flags.qualHit) begin
          stateNext       = ST_SOFT;
          strobe.clrTmr   = 1'b1;
          strobe.clrQual  = 1'b1;
          strobe.setFault = 1'b1;
        end else begin
          strobe.incTmr = 1'b1;
          if (flags.desatLive) strobe.incQual = 1'b1;
          else                 strobe.clrQual = 1'b1;
          if (state == ST_STRONG && flags.firstDone) stateNext = ST_WEAK;
        end
      end
      ST_SOFT: begin
        strobe.incTmr = 1'b1;
        if (flags.softDone) stateNext = ST_HARD;
      end
      ST_HARD: begin
        if (faultClear) begin
          stateNext       = ST_OFF;
          strobe.clrFault = 1'b1;
        end
      end
      default: stateNext = ST_OFF;
    endcase
  end

  always_comb begin
    pullUpStrong = (state == ST_STRONG);
    pullUpWeak   = (state == ST_WEAK);
    softPullDown = (state == ST_SOFT);
    pullDown     = (state == ST_OFF) || (state == ST_HARD);
    syncN        = (state != ST_SOFT);
  end

  AST_SOFT_UNINTERRUPTED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SOFT && !flags.softDone) |=> (state == ST_SOFT));  // R8

  AST_SOFT_TO_HARD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SOFT && flags.softDone) |=> (state == ST_HARD));  // R5

  AST_HARD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HARD && !faultClear) |=> (state == ST_HARD));  // R7

  AST_OFF_IGNORES_DESAT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF && !cmdOn) |=> (state == ST_OFF));  // R10

endmodule

// File: rtl/desatGuard.sv
module desatGuard
  import dsatPkg::*;
#(
  parameter int FIRST_CYC = 50,
  parameter int BLANK_CYC = 750,
  parameter int QUAL_CYC  = 250,
  parameter int SOFT_CYC  = 2312
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmdOn,
  input  logic desatIn,
  input  logic faultClear,
  output logic pullUpStrong,
  output logic pullUpWeak,
  output logic pullDown,
  output logic softPullDown,
  output logic syncN,
  output logic faultLatched
);

  dpStrobe_t strobe;
  dpFlag_t   flags;

  dsatCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdOn        (cmdOn),
    .faultClear   (faultClear),
    .flags        (flags),
    .strobe       (strobe),
    .pullUpStrong (pullUpStrong),
    .pullUpWeak   (pullUpWeak),
    .pullDown     (pullDown),
    .softPullDown (softPullDown),
    .syncN        (syncN)
  );

  dsatDatapath #(
    .FIRST_CYC (FIRST_CYC),
    .BLANK_CYC (BLANK_CYC),
    .QUAL_CYC  (QUAL_CYC),
    .SOFT_CYC  (SOFT_CYC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .desatIn (desatIn),
    .strobe  (strobe),
    .flags   (flags),
    .faultQ  (faultLatched)
  );

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rstN)
    $countones({pullUpStrong, pullUpWeak, pullDown, softPullDown}) == 1);  // R11

  AST_SOFT_AFTER_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(softPullDown) |-> $past(flags.blankDone));  // R3

  AST_WEAK_AFTER_STRONG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pullUpWeak) |-> $past(pullUpStrong));  // R2

  AST_FAULT_ON_SOFT: assert property (@(posedge clk) disable iff (!rstN)
    softPullDown |-> faultLatched);  // R6

endmodule

// File: tb/tb_desatGuard.sv
module tb_desatGuard;

  localparam int FC = 3;
  localparam int BC = 8;
  localparam int QC = 4;
  localparam int SC = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdOn = 1'b0, desatIn = 1'b0, faultClear = 1'b0;
  logic pullUpStrong, pullUpWeak, pullDown, softPullDown, syncN, faultLatched;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  desatGuard #(.FIRST_CYC(FC), .BLANK_CYC(BC), .QUAL_CYC(QC), .SOFT_CYC(SC)) dut (
    .clk(clk), .rstN(rstN), .cmdOn(cmdOn), .desatIn(desatIn), .faultClear(faultClear),
    .pullUpStrong(pullUpStrong), .pullUpWeak(pullUpWeak), .pullDown(pullDown),
    .softPullDown(softPullDown), .syncN(syncN), .faultLatched(faultLatched)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int drv();
    return {28'd0, pullUpStrong, pullUpWeak, pullDown, softPullDown};
  endfunction

  // turn on and shape desat per on-cycle index; stops at soft entry
  task automatic runOn(input int dStart, input int dLen, input int maxCyc,
                       output int onCnt, output bit hit);
    cmdOn = 1'b1; onCnt = 0; hit = 1'b0;
    for (int k = 0; k < maxCyc; k++) begin
      @(negedge clk);
      if (softPullDown) begin hit = 1'b1; break; end
      if (onCnt < FC) chk(drv() == 8, "R2 strong", drv(), 8);
      else            chk(drv() == 4, "R2 weak", drv(), 4);
      desatIn = (onCnt >= dStart && onCnt < dStart + dLen);
      onCnt++;
    end
    desatIn = 1'b0;
  endtask

  // called with soft phase visible at current negedge
  task automatic softAndClear(input bit disturb);
    int cnt;
    cnt = 1;
    chk(syncN == 1'b0 && faultLatched, "R6 soft entry", {syncN, faultLatched}, 1);
    while (1) begin
      if (disturb && cnt == 2) begin cmdOn = 1'b0; faultClear = 1'b1; end
      else faultClear = 1'b0;
      @(negedge clk);
      if (!softPullDown) break;
      cnt++;
      chk(drv() == 1 && !syncN, "R5 soft only", drv(), 1);
    end
    chk(cnt == SC, disturb ? "R8 soft length" : "R5 soft length", cnt, SC);
    chk(pullDown && syncN && faultLatched, "R7 hard", drv(), 2);
    cmdOn = 1'b1;
    repeat (4) @(negedge clk);
    chk(drv() == 2 && faultLatched, "R7 cmd ignored", drv(), 2);
    cmdOn = 1'b0; faultClear = 1'b1;
    @(negedge clk);
    faultClear = 1'b0;
    chk(drv() == 2 && !faultLatched, "R7 cleared", faultLatched, 0);
  endtask

  task automatic turnOff();
    cmdOn = 1'b0;
    @(negedge clk);
    chk(drv() == 2 && !faultLatched && syncN, "R9 off", drv(), 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int onCnt, expCnt;
    bit hit;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(drv() == 2 && syncN && !faultLatched, "R1 reset", drv(), 2);

    // R10: desat while off
    desatIn = 1'b1;
    repeat (BC + QC + 3) @(negedge clk);
    chk(drv() == 2 && !faultLatched && syncN, "R10 off desat", drv(), 2);
    desatIn = 1'b0;

    // R4: continuous desat from on-cycle d
    for (int d = 0; d <= BC + QC + 1; d++) begin
      runOn(d, 1000, 100, onCnt, hit);
      expCnt = ((d > BC) ? d : BC) + QC;
      chk(hit, "R4 qualified", hit, 1);
      chk(onCnt == expCnt, "R4 on-cycles", onCnt, expCnt);
      softAndClear(d == 2);
    end

    // R4: pulse length sweep right after blanking
    for (int l = 1; l <= QC + 1; l++) begin
      runOn(BC, l, BC + QC + 6, onCnt, hit);
      chk(hit == (l >= QC), "R4 pulse length", hit, l >= QC);
      if (hit) softAndClear(1'b0);
      else turnOff();
    end

    // R3: pulse inside blanking, and one straddling its end
    runOn(0, BC, BC + QC + 6, onCnt, hit);
    chk(!hit, "R3 inside blank", hit, 0);
    turnOff();
    runOn(BC - 1, QC, BC + QC + 6, onCnt, hit);
    chk(!hit, "R3 straddle", hit, 0);
    turnOff();

    // R9: abort during blanking with desat high
    runOn(0, 1000, 3, onCnt, hit);
    desatIn = 1'b1;
    turnOff();
    desatIn = 1'b0;

    // R8: soft phase disturbed by off and clear
    runOn(0, 1000, 100, onCnt, hit);
    chk(hit, "R8 entry", hit, 1);
    softAndClear(1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule